// File: doc/BRIEF.md
# DRAM Controller with Hidden CAS-before-RAS Refresh

This block sits between a 16-bit processor bus with separate address and data strobes and a single 1M x 16 DRAM. The memory fills the 2 MB window from 0x000000 to 0x1FFFFF. An external decoder drives a chip-select for that window. The controller runs from a clock several times faster than the processor. It latches the word address, presents it to the DRAM as a row half and then a column half, and drives the row strobe, two byte-lane column strobes, write enable and the bus acknowledge. With 60 ns parts, an access at 8 MHz completes with no wait states.

A free-running interval timer raises a refresh request for every row period. The request is served as a CAS-before-RAS cycle whenever the bus is not claiming the DRAM, so software never sees refresh. If the bus keeps the memory busy and a request has waited beyond a set limit, the refresh goes first and the next access is held off. After reset the block issues a fixed burst of refresh cycles to warm up the DRAM. Only after that does it acknowledge a processor access.

Top module: `dram_ctl`

## Requirements
- R1: While reset is held, `ras_n`, `ucas_n`, `lcas_n`, `we_n` and `dtack_n` are all high.
- R2: After reset is released, exactly `INIT_REFRESH` (default 8) CBR cycles run before the first `dtack_n` low, even if an access is waiting.
- R3: The row address `bus_addr[19:10]` (processor A20..A11) is on `dram_a` when `ras_n` falls. The column address `bus_addr[9:0]` (A10..A1) is on `dram_a` from the next cycle, and it stays stable while a CAS is low.
- R4: In an access, `ras_n` goes low one cycle before the column address appears, and both CAS lines stay high in that cycle.
- R5: In an access, `ucas_n` goes low only if `uds_n` was low, and `lcas_n` goes low only if `lds_n` was low, when the access started.
- R6: `we_n` goes low from the column-address cycle through the end of a write (`rd` = 0). It stays high for a read (`rd` = 1) and is stable while `dtack_n` is low.
- R7: An access that starts while the controller is idle and no refresh is forced gets `dtack_n` low on the third rising edge after `as_n` and `cs_n` are first sampled low. `dtack_n` returns high on the edge that samples `as_n` high.
- R8: A refresh cycle drives both CAS lines low before `ras_n` falls, with `we_n` and `dtack_n` high.
- R9: Once initialisation is over, exactly one refresh is issued per `REF_INTERVAL` clock cycles while the bus is idle.
- R10: A pending refresh never interrupts an access in progress. Once it has waited `URGENT_LIMIT` cycles it is served before the next access, which sees a later `dtack_n`.
- R11: With `as_n` low but `cs_n` high, no access starts and `dtack_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| as_n | input | 1 | Processor address strobe, active low |
| uds_n | input | 1 | Upper byte strobe, active low |
| lds_n | input | 1 | Lower byte strobe, active low |
| rd | input | 1 | 1 = read, 0 = write |
| cs_n | input | 1 | DRAM window select, active low |
| bus_addr | input | 20 | Word address, processor A20..A1 |
| dram_a | output | 10 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe |
| ucas_n | output | 1 | Upper byte column strobe |
| lcas_n | output | 1 | Lower byte column strobe |
| we_n | output | 1 | DRAM write enable |
| dtack_n | output | 1 | Data acknowledge to the processor |

## Verification
The assertions take the bus inputs to be synchronous to `clk`. They also assume that the byte strobes, `rd` and `bus_addr` are valid on the first edge that sees `as_n` low, and that `as_n` stays low until `dtack_n` has been returned. The acknowledge and byte-lane properties depend on these assumptions. The bench changes every input on the falling clock edge only. It presents the strobes together with the address strobe, and it holds a cycle until at least one edge after the acknowledge, so the stimulus stays inside these assumptions.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ROW,
      SQ_COL,
      SQ_CAS,
      SQ_PRE,
      SQ_RCAS,
      SQ_RRAS
   } sq_state_e;

   typedef struct packed {
      logic ras_n;
      logic ucas_n;
      logic lcas_n;
      logic we_n;
      logic dtack_n;
      logic sel_col;
   } pin_set_t;

   localparam pin_set_t PINS_QUIET = '{ras_n: 1'b1, ucas_n: 1'b1, lcas_n: 1'b1,
                                        we_n: 1'b1, dtack_n: 1'b1, sel_col: 1'b0};

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int INTERVAL = 496,
   parameter int LIMIT    = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ack,
   output logic pend,
   output logic urgent
);

   localparam int CW = $clog2(INTERVAL);
   localparam int WW = $clog2(LIMIT + 2);

   if (INTERVAL < 16) begin : g_bad_interval
      $error("dram_refresh_timer: INTERVAL must be at least 16");
   end
   if (LIMIT < 0) begin : g_bad_limit
      $error("dram_refresh_timer: LIMIT must not be negative");
   end

   logic [CW-1:0] cnt;
   logic          tick;

   assign tick = en && (cnt == CW'(INTERVAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
         end
         pend <= tick | (pend & ~ack);
      end
   end

   if (LIMIT == 0) begin : g_always_urgent
      assign urgent = pend;
   end else begin : g_wait_count
      logic [WW-1:0] wcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wcnt <= '0;
         end else if (!pend || ack) begin
            wcnt <= '0;
         end else if (wcnt != WW'(LIMIT)) begin
            wcnt <= wcnt + 1'b1;
         end
      end
      assign urgent = pend && (wcnt == WW'(LIMIT));
   end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int ROW_W      = 10,
   parameter int COL_W      = 10,
   parameter bit ROW_ON_TOP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [ROW_W+COL_W-1:0]   bus_addr,
   input  logic                     sel_col,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a
);

   localparam int AW = ROW_W + COL_W;
   localparam int MW = (ROW_W > COL_W) ? ROW_W : COL_W;

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("dram_addr_mux: row and column widths must be positive");
   end

   logic [AW-1:0] lat;
   logic [MW-1:0] row_v;
   logic [MW-1:0] col_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat <= '0;
      end else if (load) begin
         lat <= bus_addr;
      end
   end

   if (ROW_ON_TOP) begin : g_row_high
      assign row_v = MW'(lat[AW-1 -: ROW_W]);
      assign col_v = MW'(lat[COL_W-1:0]);
   end else begin : g_row_low
      assign row_v = MW'(lat[ROW_W-1:0]);
      assign col_v = MW'(lat[AW-1 -: COL_W]);
   end

   assign dram_a = sel_col ? col_v : row_v;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
   import dram_ctl_pkg::*;
#(
   parameter int T_RP     = 2,
   parameter int T_RRAS   = 3,
   parameter int INIT_CNT = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     as_n,
   input  logic     cs_n,
   input  logic     uds_n,
   input  logic     lds_n,
   input  logic     rd,
   input  logic     pend,
   input  logic     urgent,
   output logic     ref_ack,
   output logic     init_done,
   output logic     load_addr,
   output pin_set_t pins
);

   localparam int TMAX = (T_RP > T_RRAS) ? T_RP : T_RRAS;
   localparam int CW   = $clog2(TMAX + 1);
   localparam int IW   = $clog2(INIT_CNT + 2);

   if (T_RP < 1 || T_RRAS < 1) begin : g_bad_timing
      $error("dram_seq: precharge and refresh hold must be at least one cycle");
   end
   if (INIT_CNT < 0) begin : g_bad_init
      $error("dram_seq: INIT_CNT must not be negative");
   end

   sq_state_e     state;
   logic [CW-1:0] cnt;
   logic [IW-1:0] init_left;
   logic          acc_u, acc_l, acc_wr;
   logic          ours, start_ref, start_acc;

   assign ours      = !as_n && !cs_n;
   assign init_done = (init_left == '0);
   assign start_ref = (state == SQ_IDLE) &&
                      (!init_done || (pend && (!ours || urgent)));
   assign start_acc = (state == SQ_IDLE) && !start_ref && ours;
   assign ref_ack   = start_ref && init_done;
   assign load_addr = start_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         cnt       <= '0;
         init_left <= IW'(INIT_CNT);
         acc_u     <= 1'b0;
         acc_l     <= 1'b0;
         acc_wr    <= 1'b0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               if (start_ref) begin
                  state <= SQ_RCAS;
                  if (!init_done) init_left <= init_left - 1'b1;
               end else if (start_acc) begin
                  state  <= SQ_ROW;
                  acc_u  <= !uds_n;
                  acc_l  <= !lds_n;
                  acc_wr <= !rd;
               end
            end
            SQ_ROW: state <= SQ_COL;
            SQ_COL: state <= SQ_CAS;
            SQ_CAS: begin
               if (as_n) begin
                  state <= SQ_PRE;
                  cnt   <= CW'(T_RP - 1);
               end
            end
            SQ_PRE: begin
               if (cnt == '0) state <= SQ_IDLE;
               else           cnt   <= cnt - 1'b1;
            end
            SQ_RCAS: begin
               state <= SQ_RRAS;
               cnt   <= CW'(T_RRAS - 1);
            end
            SQ_RRAS: begin
               if (cnt == '0) begin
                  state <= SQ_PRE;
                  cnt   <= CW'(T_RP - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      pins = PINS_QUIET;
      unique case (state)
         SQ_ROW: pins.ras_n = 1'b0;
         SQ_COL: begin
            pins.ras_n   = 1'b0;
            pins.sel_col = 1'b1;
            pins.we_n    = !acc_wr;
         end
         SQ_CAS: begin
            pins.ras_n   = 1'b0;
            pins.sel_col = 1'b1;
            pins.we_n    = !acc_wr;
            pins.ucas_n  = !acc_u;
            pins.lcas_n  = !acc_l;
            pins.dtack_n = 1'b0;
         end
         SQ_RCAS: begin
            pins.ucas_n = 1'b0;
            pins.lcas_n = 1'b0;
         end
         SQ_RRAS: begin
            pins.ras_n  = 1'b0;
            pins.ucas_n = 1'b0;
            pins.lcas_n = 1'b0;
         end
         default: pins = PINS_QUIET;
      endcase
   end

   AST_NO_ACK_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> pins.dtack_n); // R2

   AST_ACK_NEEDS_AS: assert property (@(posedge clk) disable iff (!rst_n)
      !pins.dtack_n |-> $past(!as_n)); // R7

   AST_URGENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && urgent && init_done) |=> (state == SQ_RCAS)); // R10

   AST_UPPER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pins.dtack_n) && !pins.ucas_n) |-> $past(!uds_n, 3)); // R5

   AST_LOWER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pins.dtack_n) && !pins.lcas_n) |-> $past(!lds_n, 3)); // R5

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
   import dram_ctl_pkg::*;
#(
   parameter int ROW_W        = 10,
   parameter int COL_W        = 10,
   parameter bit ROW_ON_TOP   = 1'b1,
   parameter int REF_INTERVAL = 496,
   parameter int URGENT_LIMIT = 64,
   parameter int T_RP         = 2,
   parameter int T_RRAS       = 3,
   parameter int INIT_REFRESH = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   as_n,
   input  logic                   uds_n,
   input  logic                   lds_n,
   input  logic                   rd,
   input  logic                   cs_n,
   input  logic [ROW_W+COL_W-1:0] bus_addr,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
   output logic                   ras_n,
   output logic                   ucas_n,
   output logic                   lcas_n,
   output logic                   we_n,
   output logic                   dtack_n
);

   pin_set_t pins;
   logic     pend, urgent, ref_ack, init_done, load_addr;

   dram_refresh_timer #(
      .INTERVAL (REF_INTERVAL),
      .LIMIT    (URGENT_LIMIT)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (init_done),
      .ack    (ref_ack),
      .pend   (pend),
      .urgent (urgent)
   );

   dram_seq #(
      .T_RP     (T_RP),
      .T_RRAS   (T_RRAS),
      .INIT_CNT (INIT_REFRESH)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .as_n      (as_n),
      .cs_n      (cs_n),
      .uds_n     (uds_n),
      .lds_n     (lds_n),
      .rd        (rd),
      .pend      (pend),
      .urgent    (urgent),
      .ref_ack   (ref_ack),
      .init_done (init_done),
      .load_addr (load_addr),
      .pins      (pins)
   );

   dram_addr_mux #(
      .ROW_W      (ROW_W),
      .COL_W      (COL_W),
      .ROW_ON_TOP (ROW_ON_TOP)
   ) u_amux (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_addr),
      .bus_addr (bus_addr),
      .sel_col  (pins.sel_col),
      .dram_a   (dram_a)
   );

   assign ras_n   = pins.ras_n;
   assign ucas_n  = pins.ucas_n;
   assign lcas_n  = pins.lcas_n;
   assign we_n    = pins.we_n;
   assign dtack_n = pins.dtack_n;

   AST_RAS_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && ($fell(ucas_n) || $fell(lcas_n))) |-> $past(!ras_n)); // R4

   AST_CBR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !ucas_n) |-> ($past(!ucas_n) && $past(!lcas_n) && we_n && dtack_n)); // R8

   AST_COL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && (!ucas_n || !lcas_n) && $past(!ras_n && (!ucas_n || !lcas_n)))
         |-> $stable(dram_a)); // R3

   AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!dtack_n && $past(!dtack_n)) |-> $stable(we_n)); // R6

   AST_NO_ACK_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n) |-> $past(!cs_n, 3)); // R11

endmodule

// File: tb/dram_ctl_bench.sv
`timescale 1ns/1ps
module dram_ctl_bench;

   localparam int NV = 8;
   // stimulus {addr[19:0], uds_n, lds_n, rd} and expected {ucas_n, lcas_n, we_n}
   localparam logic [25:0] VEC [NV] = '{
      {20'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
      {20'hFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {20'h5A5A5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {20'hA5A5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
      {20'h003FF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
      {20'hFFC00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
      {20'h12345, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {20'h80001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n, as_n, uds_n, lds_n, rd, cs_n;
   logic [19:0] bus_addr;
   logic [9:0]  dram_a;
   logic        ras_n, ucas_n, lcas_n, we_n, dtack_n;

   int n_chk = 0;
   int n_bad = 0;
   int cbr_total = 0;
   int cbr_bad = 0;
   logic prev_ras = 1'b1;
   bit   wd_fired = 1'b0;

   always #2 clk = ~clk;

   dram_ctl #(
      .REF_INTERVAL (400),
      .URGENT_LIMIT (12)
   ) u_dram_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .as_n     (as_n),
      .uds_n    (uds_n),
      .lds_n    (lds_n),
      .rd       (rd),
      .cs_n     (cs_n),
      .bus_addr (bus_addr),
      .dram_a   (dram_a),
      .ras_n    (ras_n),
      .ucas_n   (ucas_n),
      .lcas_n   (lcas_n),
      .we_n     (we_n),
      .dtack_n  (dtack_n)
   );

   // refresh monitor: RAS falling while both CAS lines are already low
   always @(negedge clk) begin
      if (prev_ras && !ras_n && !ucas_n && !lcas_n) begin
         cbr_total = cbr_total + 1;
         if (!we_n || !dtack_n) cbr_bad = cbr_bad + 1;
      end
      prev_ras = ras_n;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_idle();
      as_n = 1'b1; cs_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rd = 1'b1;
   endtask

   task automatic run_vec(input logic [25:0] v);
      logic [19:0] a;
      a = v[25:6];
      bus_addr = a; uds_n = v[5]; lds_n = v[4]; rd = v[3];
      cs_n = 1'b0; as_n = 1'b0;
      @(negedge clk);
      chk(ras_n == 1'b0, "R4 RAS low in row cycle", ras_n, 0);
      chk({ucas_n, lcas_n} == 2'b11, "R4 CAS high in row cycle", {ucas_n, lcas_n}, 3);
      chk(dram_a == a[19:10], "R3 row address", dram_a, a[19:10]);
      @(negedge clk);
      chk(dram_a == a[9:0], "R3 column address", dram_a, a[9:0]);
      chk(we_n == v[0], "R6 write enable", we_n, v[0]);
      chk(dtack_n == 1'b1, "R7 no early ack", dtack_n, 1);
      @(negedge clk);
      chk(dtack_n == 1'b0, "R7 ack on third edge", dtack_n, 0);
      chk(ucas_n == v[2], "R5 upper CAS", ucas_n, v[2]);
      chk(lcas_n == v[1], "R5 lower CAS", lcas_n, v[1]);
      chk(dram_a == a[9:0], "R3 column held under CAS", dram_a, a[9:0]);
      @(negedge clk);
      bus_idle();
      @(negedge clk);
      chk(dtack_n == 1'b1, "R7 ack released", dtack_n, 1);
      chk(ras_n == 1'b1, "R7 RAS released", ras_n, 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic run_all();
      int base, lat, bad;
      // R1 reset state
      repeat (4) @(negedge clk);
      chk({ras_n, ucas_n, lcas_n, we_n, dtack_n} == 5'h1f, "R1 outputs idle in reset",
          {ras_n, ucas_n, lcas_n, we_n, dtack_n}, 5'h1f);

      // R2 init refreshes with an access already waiting
      bus_addr = 20'h000C3; uds_n = 1'b0; lds_n = 1'b0; rd = 1'b1;
      cs_n = 1'b0; as_n = 1'b0;
      base = cbr_total;
      rst_n = 1'b1;
      lat = 0;
      while (dtack_n && lat < 300) begin
         @(negedge clk);
         lat++;
      end
      chk(dtack_n == 1'b0, "R2 access acknowledged after init", dtack_n, 0);
      chk(cbr_total - base == 8, "R2 refresh count before first ack", cbr_total - base, 8);
      chk(cbr_bad == 0, "R8 CBR with WE and ack high", cbr_bad, 0);
      bus_idle();
      repeat (3) @(negedge clk);

      // table walk: R3 R4 R5 R6 R7
      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R11 unselected bus cycle
      bus_addr = 20'h33333; uds_n = 1'b0; lds_n = 1'b0; rd = 1'b0;
      cs_n = 1'b1; as_n = 1'b0;
      bad = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (!dtack_n || (!ras_n && ucas_n)) bad++;
      end
      chk(bad == 0, "R11 no access without select", bad, 0);
      bus_idle();
      repeat (2) @(negedge clk);

      // R9 periodic refresh on an idle bus
      base = cbr_total;
      lat = 0;
      while (cbr_total == base && lat < 500) begin
         @(negedge clk);
         lat++;
      end
      chk(cbr_total != base, "R9 refresh served on idle bus", cbr_total - base, 1);
      base = cbr_total;
      repeat (600) @(negedge clk);
      chk(cbr_total - base == 1, "R9 one refresh per interval", cbr_total - base, 1);

      // R10 long access holds off refresh, then urgent refresh delays next access
      bus_addr = 20'h77777; uds_n = 1'b0; lds_n = 1'b0; rd = 1'b0;
      cs_n = 1'b0; as_n = 1'b0;
      @(negedge clk);
      base = cbr_total;
      bad = 0;
      for (int k = 0; k < 430; k++) begin
         @(negedge clk);
         if (ras_n) bad++;
      end
      chk(bad == 0 && cbr_total == base, "R10 no refresh inside own access", bad, 0);
      bus_idle();
      @(negedge clk);
      bus_addr = 20'h0ABCD; uds_n = 1'b0; lds_n = 1'b0; rd = 1'b1;
      cs_n = 1'b0; as_n = 1'b0;
      base = cbr_total;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (dtack_n && lat < 60);
      chk(cbr_total - base == 1, "R10 urgent refresh before next access", cbr_total - base, 1);
      chk(lat > 3, "R10 next access delayed", lat, 4);
      chk(cbr_bad == 0, "R8 CBR shape throughout", cbr_bad, 0);
      bus_idle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0;
      bus_addr = '0;
      bus_idle();
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            wd_fired = 1'b1;
         end
      join_any
      disable fork;
      if (wd_fired) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1..all actual=hung expected=finished");
      end
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule